// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block sits between a host register port and an external two-channel 10-bit analog converter and runs each conversion for it. Software programs a clock divider, powers up the converter with an enable bit, and after a setup interval launches a conversion by writing a start bit. The controller then pulses a converter clock enable at the divided rate, keeps the channel choice stable towards the converter, counts the conversion window, and captures the 10-bit result when the window closes.

At the end of the window the start bit clears by itself, a sticky end flag is set, and an interrupt is raised if the interrupt enable is set. When software asks for it with the start write, the controller also raises an idle-hold request towards the CPU for the length of the conversion.

Register map (2-bit address, 8-bit data): address 0 is control, address 1 is the divider (bits 4:0), address 2 is the upper eight result bits, address 3 holds the lower two result bits in bits 1:0. Control bits: 0 enable, 1 start/busy, 2 end flag, 3 interrupt enable, 4 channel, 5 idle-hold request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, and conv_clk_en, conv_chan, irq and idle_hold are 0.
- R2: conv_clk_en, while enable is 1, pulses once every (divider+1) clocks; a divider of 0 gives a pulse on every clock.
- R3: A start write (control bit 1 = 1) is ignored while enable (control bit 0) is 0, or until SETUP_TICKS converter ticks (default 4) have passed since enable was set; a start in the same write that sets enable is ignored.
- R4: An accepted start makes control bit 1 read 1 from the next clock for exactly CONV_TICKS (default 11) converter ticks; it clears on the edge of the last tick.
- R5: On the closing edge the result input is captured: address 2 reads result[9:2], address 3 reads result[1:0] in bits 1:0 with bits 7:2 zero; both change on the same edge.
- R6: The end flag (control bit 2) is set on the closing edge and stays set until a control write with bit 2 = 0; a control write with bit 2 = 1 leaves it unchanged.
- R7: irq is 1 exactly when the end flag and the interrupt enable (control bit 3) are both 1.
- R8: idle_hold is 1 during a conversion only when control bit 5 was 1 in the accepted start write, and is 0 outside conversions.
- R9: conv_chan shows control bit 4 from the accepted start write and does not change for the rest of that conversion, even if control is rewritten.
- R10: If a software clear of the end flag falls on the same edge as the end of a conversion, the flag ends up set.
- R11: A start write during a conversion neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| conv_clk_en | output | 1 | Converter clock enable pulse |
| conv_chan | output | 1 | Channel select to converter |
| conv_result | input | 10 | Converter result, captured at end of conversion |
| irq | output | 1 | End-of-conversion interrupt request |
| idle_hold | output | 1 | CPU idle-hold request during conversion |

## Verification
The hardware setting of the end flag at the close of a conversion and a software write that clears it can land on the same clock edge. The bench provokes this with a divider of 0, so the closing edge is exactly the eleventh edge after the start write, and places a control write with bit 2 = 0 on that edge while the flag is already set. It judges the outcome by reading the flag set and the busy bit clear afterwards, then confirms that a later clear alone works.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int RES_W   = 10;
    localparam int RES_LO_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DIV  = 2'd1,
        ADDR_DHI  = 2'd2,
        ADDR_DLO  = 2'd3
    } reg_addr_e;

    localparam int CB_EN   = 0;
    localparam int CB_GO   = 1;
    localparam int CB_DONE = 2;
    localparam int CB_IE   = 3;
    localparam int CB_CH   = 4;
    localparam int CB_HOLD = 5;

    typedef struct packed {
        logic hold;
        logic ch;
        logic ie;
        logic en;
    } ctrl_cfg_t;

    typedef struct packed {
        logic ch;
        logic hold;
    } conv_req_t;

    function automatic ctrl_cfg_t decode_cfg(input logic [REG_W-1:0] w);
        ctrl_cfg_t c;
        c.hold = w[CB_HOLD];
        c.ch   = w[CB_CH];
        c.ie   = w[CB_IE];
        c.en   = w[CB_EN];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_ctrl(input ctrl_cfg_t c,
                                                     input logic busy,
                                                     input logic eoc);
        logic [REG_W-1:0] r;
        r          = '0;
        r[CB_EN]   = c.en;
        r[CB_GO]   = busy;
        r[CB_DONE] = eoc;
        r[CB_IE]   = c.ie;
        r[CB_CH]   = c.ch;
        r[CB_HOLD] = c.hold;
        return r;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div_val);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R2: with a nonzero divider two ticks never sit back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && div_val != '0) |=> (!tick || div_val != $past(div_val)));

endmodule

// File: rtl/adc_setup_timer.sv
module adc_setup_timer #(
    parameter int SETUP_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    output logic ready
);
    localparam int CW = $clog2(SETUP_TICKS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(SETUP_TICKS);

    logic [CW-1:0] cnt;

    assign ready = enable && (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !enable)              cnt <= '0;
        else if (tick && cnt != LIMIT)   cnt <= cnt + 1'b1;
    end

    // R3: setup completes only on a converter tick
    assert_ready_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (SETUP_TICKS == 0 || $past(tick)));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int CONV_TICKS = 11
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_req,
    input  logic      ready,
    input  logic      tick,
    input  conv_req_t req,
    output logic      busy,
    output logic      done,
    output logic      chan,
    output logic      hold
);
    localparam int CW = $clog2(CONV_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_TICKS - 1);

    logic [CW-1:0] cnt;
    conv_req_t     lat;

    assign done = busy && tick && (cnt == LAST);
    assign chan = lat.ch;
    assign hold = busy && lat.hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            lat  <= '0;
        end else if (!busy) begin
            if (start_req && ready) begin
                busy <= 1'b1;
                cnt  <= '0;
                lat  <= req;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: a conversion only begins when setup has finished
    assert_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ready));

    // R4: the window closes only on a converter tick
    assert_end_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));

    // R4: tick count never passes the window length
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

    // R9: channel held steady for the whole conversion
    assert_chan_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(chan));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W       = 5,
    parameter int SETUP_TICKS = 4,
    parameter int CONV_TICKS  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              conv_clk_en,
    output logic              conv_chan,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq,
    output logic              idle_hold
);
    localparam int HI_W = RES_W - RES_LO_W;

    ctrl_cfg_t               cfg;
    logic [DIV_W-1:0]        div_val;
    logic                    eoc;
    logic [HI_W-1:0]         data_hi;
    logic [RES_LO_W-1:0]     data_lo;

    logic      tick, ready, busy, done, start_req, ctrl_wr, div_wr, clr_req;
    conv_req_t req;

    assign ctrl_wr   = reg_we && (reg_addr == ADDR_CTRL);
    assign div_wr    = reg_we && (reg_addr == ADDR_DIV);
    assign start_req = ctrl_wr && reg_wdata[CB_GO];
    assign clr_req   = ctrl_wr && !reg_wdata[CB_DONE];
    assign req.ch    = reg_wdata[CB_CH];
    assign req.hold  = reg_wdata[CB_HOLD];

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_val (div_val),
        .tick    (tick)
    );

    adc_setup_timer #(.SETUP_TICKS(SETUP_TICKS)) u_setup (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg.en),
        .tick   (tick),
        .ready  (ready)
    );

    adc_conv_seq #(.CONV_TICKS(CONV_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .ready     (ready),
        .tick      (tick),
        .req       (req),
        .busy      (busy),
        .done      (done),
        .chan      (conv_chan),
        .hold      (idle_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            div_val <= '0;
            eoc     <= 1'b0;
            data_hi <= '0;
            data_lo <= '0;
        end else begin
            if (ctrl_wr) cfg <= decode_cfg(reg_wdata);
            if (div_wr)  div_val <= reg_wdata[DIV_W-1:0];
            if (done) begin
                eoc     <= 1'b1;
                data_hi <= conv_result[RES_W-1:RES_LO_W];
                data_lo <= conv_result[RES_LO_W-1:0];
            end else if (clr_req) begin
                eoc <= 1'b0;
            end
        end
    end

    assign conv_clk_en = tick && cfg.en;
    assign irq         = eoc && cfg.ie;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = encode_ctrl(cfg, busy, eoc);
            ADDR_DIV:  reg_rdata[DIV_W-1:0] = div_val;
            ADDR_DHI:  reg_rdata[HI_W-1:0] = data_hi;
            ADDR_DLO:  reg_rdata[RES_LO_W-1:0] = data_lo;
            default:   reg_rdata = '0;
        endcase
    end

    // R6: the end flag is up whenever a conversion has just closed
    assert_eoc_on_end_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> eoc);

    // R6: the flag only drops through a software clear
    assert_eoc_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (eoc && !clr_req) |=> eoc);

    // R8: idle-hold appears only inside a conversion
    assert_hold_in_conv_R8: assert property (@(posedge clk) disable iff (rst)
        idle_hold |-> busy);

    // R5: result registers move only when a conversion closes
    assert_data_on_end_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(done) |-> ($stable(data_hi) && $stable(data_lo)));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCONV = 11;

    localparam logic [7:0] EN = 8'h01, GO = 8'h02, DN = 8'h04,
                           IE = 8'h08, CH = 8'h10, HD = 8'h20;

    // {divider[4:0], channel, idle-hold, result[9:0]}
    localparam logic [16:0] VEC [4] = '{
        {5'd0, 1'b0, 1'b0, 10'h3FF},
        {5'd1, 1'b1, 1'b1, 10'h155},
        {5'd3, 1'b0, 1'b1, 10'h2A6},
        {5'd7, 1'b1, 1'b0, 10'h001}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       conv_clk_en, conv_chan, irq, idle_hold;
    logic [9:0] conv_result = 10'd0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    adc_seq_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .conv_clk_en (conv_clk_en),
        .conv_chan   (conv_chan),
        .conv_result (conv_result),
        .irq         (irq),
        .idle_hold   (idle_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller stands at a negedge; write takes effect on the next posedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        int k, gap, busy_n;
        logic [4:0] dv;
        logic chv, hdv;
        logic [9:0] res;
        logic [7:0] ctl;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", 16'(v), 16'h0);
        rd(2'd1, v); chk("R1 div", 16'(v), 16'h0);
        rd(2'd2, v); chk("R1 dhi", 16'(v), 16'h0);
        rd(2'd3, v); chk("R1 dlo", 16'(v), 16'h0);
        chk("R1 outs", 16'({conv_clk_en, conv_chan, irq, idle_hold}), 16'h0);

        // R3: start while disabled
        @(negedge clk);
        wr(2'd0, GO);
        rd(2'd0, v); chk("R3 start while disabled", 16'(v[1]), 16'h0);
        // R3: start together with enable, then right after enable
        wr(2'd0, EN | GO);
        rd(2'd0, v); chk("R3 start with enable", 16'(v[1]), 16'h0);
        wr(2'd0, EN | GO);
        rd(2'd0, v); chk("R3 start in setup", 16'(v[1]), 16'h0);
        repeat (20) @(negedge clk);

        // R2 divider 0: pulse every clock
        wr(2'd1, 8'd0);
        k = 0;
        for (int i = 0; i < 4; i++) begin
            #1; if (conv_clk_en) k++;
            @(negedge clk);
        end
        chk("R2 div0 pulses", 16'(k), 16'd4);
        // R2 divider 2: period 3
        wr(2'd1, 8'd2);
        while (!conv_clk_en) @(negedge clk);
        @(negedge clk);
        gap = 1;
        while (!conv_clk_en && gap < 50) begin gap++; @(negedge clk); end
        chk("R2 div2 period", 16'(gap), 16'd3);

        // vector walk: R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 4; n++) begin
            dv  = VEC[n][16:12];
            chv = VEC[n][11];
            hdv = VEC[n][10];
            res = VEC[n][9:0];
            conv_result = res;
            wr(2'd1, {3'b0, dv});
            ctl = EN | GO | (chv ? CH : 8'h0) | (hdv ? HD : 8'h0) | ((n % 2 == 1) ? IE : 8'h0);
            wr(2'd0, ctl);
            k = 0; busy_n = 0;
            rd(2'd0, v);
            while (v[1] && busy_n < 500) begin
                if (conv_chan !== chv || idle_hold !== hdv) begin
                    chk("R8/R9 during conversion", 16'({conv_chan, idle_hold}), 16'({chv, hdv}));
                end
                if (conv_clk_en) k++;
                busy_n++;
                @(negedge clk);
                rd(2'd0, v);
            end
            chk("R4 window ticks", 16'(k), 16'(NCONV));
            chk("R6 end flag set", 16'(v[2]), 16'h1);
            chk("R8 hold released", 16'(idle_hold), 16'h0);
            chk("R7 irq follows ie", 16'(irq), 16'(n % 2 == 1));
            rd(2'd2, v); chk("R5 high byte", 16'(v), 16'(res[9:2]));
            rd(2'd3, v); chk("R5 low byte", 16'(v), 16'({6'b0, res[1:0]}));
            @(negedge clk);
        end

        // R6: writing 1 to the flag keeps it; writing 0 clears it
        wr(2'd0, EN | IE | DN);
        rd(2'd0, v); chk("R6 write 1 keeps", 16'(v[2]), 16'h1);
        chk("R7 irq on", 16'(irq), 16'h1);
        wr(2'd0, EN | DN);
        chk("R7 irq off with ie 0", 16'(irq), 16'h0);
        rd(2'd0, v); chk("R7 flag kept", 16'(v[2]), 16'h1);
        wr(2'd0, EN | IE);
        rd(2'd0, v); chk("R6 clear", 16'(v[2]), 16'h0);
        chk("R7 irq cleared", 16'(irq), 16'h0);

        // R9/R11: restart attempt and channel rewrite mid conversion, div 0
        wr(2'd1, 8'd0);
        conv_result = 10'h2C3;
        wr(2'd0, EN | GO);
        busy_n = 0;
        for (int i = 0; i < 20; i++) begin
            rd(2'd0, v);
            if (v[1]) busy_n++;
            if (i == 4) begin reg_we = 1'b1; reg_wdata = EN | GO | CH; end
            if (i == 5) begin
                reg_we = 1'b0;
                chk("R9 chan kept", 16'(conv_chan), 16'h0);
            end
            @(negedge clk);
        end
        chk("R11 no restart", 16'(busy_n), 16'(NCONV));
        rd(2'd2, v); chk("R5 high byte 2", 16'(v), 16'h00B0);

        // R10: clear on the closing edge; flag currently set
        wr(2'd0, EN | GO | DN);
        repeat (10) @(negedge clk);
        wr(2'd0, EN);
        rd(2'd0, v);
        chk("R10 set wins busy", 16'(v[1]), 16'h0);
        chk("R10 set wins flag", 16'(v[2]), 16'h1);
        wr(2'd0, EN);
        rd(2'd0, v); chk("R10 later clear", 16'(v[2]), 16'h0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule